// File: doc/BRIEF.md
# Switch-on-Miss Thread Scheduler

This block steers a block-multithreaded in-order pipeline that changes threads whenever a cache miss stalls the running thread. It keeps one running thread and a first-in first-out queue of threads that are ready to run. When a stage reports a memory stall for the running thread, the scheduler stores the stalling instruction's tag in a holding slot for that stage and thread. It suspends the thread in the same cycle and hands the pipeline to the oldest queued thread.

When the miss returns, the completion names the owning thread. If another thread is running, the owner waits its turn at the tail of the queue. If nothing is running, the owner is started at once. Each activation also replays the thread's parked instructions: every stage whose slot for that thread holds a tag sends it back toward its skid buffer with a one-cycle pulse, and the slot is freed.

All outputs are registered. A stall report or completion presented in cycle N shows its effect on the outputs just after the clock edge that ends cycle N.

Top module: `swmiss_sched`

## Requirements
- R1: After reset, thread 0 is running (`run_valid`=1, `run_tid`=0), the ready queue is empty, all holding slots are empty, and `wake`, `switch_fail` and `ri_valid` are low.
- R2: A stall report from the running thread stores `stall_tag` in the holding slot selected by `stall_stage` and `stall_tid`, and that thread stops running at the next edge.
- R3: On an accepted stall with a non-empty queue, the queue head becomes the running thread at the next edge. Threads leave the queue in arrival order, and `wake` pulses high for one cycle.
- R4: On an accepted stall with an empty queue, `run_valid` goes low and `switch_fail` pulses high for one cycle.
- R5: A completion for a thread other than the one running leaves the running thread unchanged and appends the completed thread to the queue tail.
- R6: A completion that arrives while no thread is running makes that thread run at the next edge, with a one-cycle `wake` pulse.
- R7: On any activation, each stage s whose slot for the activated thread is occupied raises `ri_valid[s]` for exactly one cycle. In that cycle `ri_tid` holds the thread and `ri_tag[s*TAG_W +: TAG_W]` holds the stored tag. The slot is then empty, so a later activation does not replay it.
- R8: A stage whose slot for the activated thread is empty keeps `ri_valid[s]` low.
- R9: A completion for a thread already in the queue, or for the running thread, changes neither the queue nor the running thread.
- R10: When a stall and a completion arrive in the same cycle, the suspend and switch are done first and the completion is applied afterwards. A completion for the just-stalled thread with an empty queue restarts it and replays the tag stored in that cycle.
- R11: A stall report whose thread is not the running thread, or that arrives while no thread runs, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_valid | input | 1 | Memory-stall report strobe |
| stall_tid | input | TID_W | Thread of the stalling instruction |
| stall_stage | input | STG_W | Stage holding the stalling instruction |
| stall_tag | input | TAG_W | Tag of the stalling instruction |
| done_valid | input | 1 | Miss-completion strobe |
| done_tid | input | TID_W | Thread owning the completed miss |
| run_valid | output | 1 | A thread is running |
| run_tid | output | TID_W | Running thread |
| wake | output | 1 | One-cycle pulse when a thread is started |
| switch_fail | output | 1 | One-cycle pulse when a switch found the queue empty |
| ri_valid | output | NUM_STAGES | Per-stage reinsert pulse |
| ri_tid | output | TID_W | Thread of the reinserted instructions |
| ri_tag | output | NUM_STAGES*TAG_W | Per-stage reinserted tag |

## Verification
The bench targets the cases where ordering matters. A same-cycle stall and completion catches a design that applies the completion first and enqueues the thread instead of starting it. A stall and a completion on the same thread with an empty queue catches a replay that misses the tag written in that very cycle. A repeated completion for a queued thread catches a queue that admits duplicates and later starts a thread twice. A thread activated a second time catches slots that are never cleared, which would replay a stale tag. Stalls from a non-running thread, and stalls while nothing runs, catch a design that switches or parks on bogus reports.

// File: rtl/swmiss_sched_pkg.sv
package swmiss_sched_pkg;
   localparam int unsigned DEF_THREADS = 4;
   localparam int unsigned DEF_STAGES  = 3;
   localparam int unsigned DEF_TAG_W   = 16;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/swmiss_ready_fifo.sv
module swmiss_ready_fifo
   import swmiss_sched_pkg::*;
#(
   parameter int unsigned THREADS = DEF_THREADS,
   parameter int unsigned TID_W   = bits_for(THREADS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [TID_W-1:0]   push_tid,
   input  logic               pop,
   output logic [TID_W-1:0]   head,
   output logic               empty,
   output logic [THREADS-1:0] member
);
   localparam int unsigned CNT_W = $clog2(THREADS + 1);

   logic [TID_W-1:0] slots [THREADS];
   logic [TID_W-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             push_ok, pop_ok, full;

   // pointer wrap: free when depth is a power of two, compared otherwise
   generate
      if ((THREADS & (THREADS - 1)) == 0) begin : g_wrap_pow2
         always_comb begin
            rd_nxt = rd_q + 1'b1;
            wr_nxt = wr_q + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            rd_nxt = (rd_q == TID_W'(THREADS - 1)) ? '0 : rd_q + 1'b1;
            wr_nxt = (wr_q == TID_W'(THREADS - 1)) ? '0 : wr_q + 1'b1;
         end
      end
   endgenerate

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(THREADS));
   assign head    = slots[rd_q];
   assign pop_ok  = pop && !empty;
   assign push_ok = push && !member[push_tid] && (!full || pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok) slots[wr_q] <= push_tid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q   <= '0;
         wr_q   <= '0;
         cnt_q  <= '0;
         member <= '0;
      end else begin
         if (pop_ok) begin
            rd_q               <= rd_nxt;
            member[slots[rd_q]] <= 1'b0;
         end
         if (push_ok) begin
            wr_q             <= wr_nxt;
            member[push_tid] <= 1'b1;
         end
         if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
         else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/swmiss_hold_bank.sv
module swmiss_hold_bank
   import swmiss_sched_pkg::*;
#(
   parameter int unsigned THREADS = DEF_THREADS,
   parameter int unsigned STAGES  = DEF_STAGES,
   parameter int unsigned TAG_W   = DEF_TAG_W,
   parameter int unsigned TID_W   = bits_for(THREADS),
   parameter int unsigned STG_W   = bits_for(STAGES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [STG_W-1:0]        wr_stage,
   input  logic [TID_W-1:0]        wr_tid,
   input  logic [TAG_W-1:0]        wr_tag,
   input  logic                    act,
   input  logic [TID_W-1:0]        act_tid,
   output logic [STAGES-1:0]       ri_valid,
   output logic [TID_W-1:0]        ri_tid,
   output logic [STAGES*TAG_W-1:0] ri_tag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   ri_tid <= '0;
      else if (act) ri_tid <= act_tid;
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [THREADS-1:0] held_q;
         logic [TAG_W-1:0]   tag_mem [THREADS];
         logic [TAG_W-1:0]   out_tag_q;
         logic               out_vld_q;
         logic               wr_here, bypass;

         assign wr_here = wr_en && (wr_stage == STG_W'(s));
         assign bypass  = wr_here && (wr_tid == act_tid);

         always_ff @(posedge clk) begin
            if (wr_here) tag_mem[wr_tid] <= wr_tag;
            if (act)     out_tag_q <= bypass ? wr_tag : tag_mem[act_tid];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q    <= '0;
               out_vld_q <= 1'b0;
            end else begin
               out_vld_q <= act && (held_q[act_tid] || bypass);
               if (wr_here) held_q[wr_tid]  <= 1'b1;
               if (act)     held_q[act_tid] <= 1'b0;
            end
         end

         assign ri_valid[s]                 = out_vld_q;
         assign ri_tag[s*TAG_W +: TAG_W]    = out_tag_q;
      end
   endgenerate
endmodule

// File: rtl/swmiss_sched.sv
module swmiss_sched
   import swmiss_sched_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_STAGES  = DEF_STAGES,
   parameter int unsigned TAG_W       = DEF_TAG_W,
   parameter int unsigned TID_W       = bits_for(NUM_THREADS),
   parameter int unsigned STG_W       = bits_for(NUM_STAGES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        stall_valid,
   input  logic [TID_W-1:0]            stall_tid,
   input  logic [STG_W-1:0]            stall_stage,
   input  logic [TAG_W-1:0]            stall_tag,
   input  logic                        done_valid,
   input  logic [TID_W-1:0]            done_tid,
   output logic                        run_valid,
   output logic [TID_W-1:0]            run_tid,
   output logic                        wake,
   output logic                        switch_fail,
   output logic [NUM_STAGES-1:0]       ri_valid,
   output logic [TID_W-1:0]            ri_tid,
   output logic [NUM_STAGES*TAG_W-1:0] ri_tag
);
   generate
      if (NUM_THREADS < 2)            begin : g_chk_thr $error("need at least two threads"); end
      if ((1 << TID_W) < NUM_THREADS) begin : g_chk_tid $error("TID_W too narrow"); end
      if ((1 << STG_W) < NUM_STAGES)  begin : g_chk_stg $error("STG_W too narrow"); end
      if (NUM_STAGES < 1 || TAG_W < 1) begin : g_chk_sz $error("bad stage count or tag width"); end
   endgenerate

   logic                   q_empty;
   logic [TID_W-1:0]       q_head;
   logic [NUM_THREADS-1:0] q_member;
   logic                   stall_ok, pop, push;
   logic                   mid_valid;
   logic [TID_W-1:0]       mid_tid;
   logic                   act;
   logic [TID_W-1:0]       act_tid;
   logic                   fail_now;

   // step 1: suspend and switch; step 2: apply the completion on the result
   always_comb begin
      stall_ok  = stall_valid && run_valid && (stall_tid == run_tid);
      pop       = stall_ok && !q_empty;
      fail_now  = stall_ok && q_empty;
      mid_valid = stall_ok ? !q_empty : run_valid;
      mid_tid   = pop ? q_head : run_tid;
      push      = done_valid && mid_valid && (done_tid != mid_tid);
      act       = pop || (done_valid && !mid_valid);
      act_tid   = pop ? q_head : done_tid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_valid   <= 1'b1;
         run_tid     <= '0;
         wake        <= 1'b0;
         switch_fail <= 1'b0;
      end else begin
         run_valid   <= mid_valid || act;
         run_tid     <= act ? act_tid : run_tid;
         wake        <= act;
         switch_fail <= fail_now;
      end
   end

   swmiss_ready_fifo #(
      .THREADS (NUM_THREADS),
      .TID_W   (TID_W)
   ) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_tid (done_tid),
      .pop      (pop),
      .head     (q_head),
      .empty    (q_empty),
      .member   (q_member)
   );

   swmiss_hold_bank #(
      .THREADS (NUM_THREADS),
      .STAGES  (NUM_STAGES),
      .TAG_W   (TAG_W),
      .TID_W   (TID_W),
      .STG_W   (STG_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (stall_ok),
      .wr_stage (stall_stage),
      .wr_tid   (stall_tid),
      .wr_tag   (stall_tag),
      .act      (act),
      .act_tid  (act_tid),
      .ri_valid (ri_valid),
      .ri_tid   (ri_tid),
      .ri_tag   (ri_tag)
   );

   logic unused_member;
   assign unused_member = ^q_member;
endmodule

// File: rtl/swmiss_sched_chk.sv
module swmiss_sched_chk #(
   parameter int unsigned NUM_THREADS = 4,
   parameter int unsigned NUM_STAGES  = 3,
   parameter int unsigned TAG_W       = 16,
   parameter int unsigned TID_W       = 2,
   parameter int unsigned STG_W       = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        stall_valid,
   input logic [TID_W-1:0]            stall_tid,
   input logic [STG_W-1:0]            stall_stage,
   input logic [TAG_W-1:0]            stall_tag,
   input logic                        done_valid,
   input logic [TID_W-1:0]            done_tid,
   input logic                        run_valid,
   input logic [TID_W-1:0]            run_tid,
   input logic                        wake,
   input logic                        switch_fail,
   input logic [NUM_STAGES-1:0]       ri_valid,
   input logic [TID_W-1:0]            ri_tid,
   input logic [NUM_STAGES*TAG_W-1:0] ri_tag
);
   // R2
   stall_suspends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_valid && run_valid && stall_tid == run_tid && !done_valid)
      |=> (!run_valid || run_tid != $past(stall_tid)));

   // R6
   idle_done_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_valid && done_valid)
      |=> (run_valid && wake && run_tid == $past(done_tid)));

   // R7
   replay_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ri_valid != '0) |-> wake);

   // R3
   wake_implies_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> run_valid);

   // R11
   quiet_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_valid && !done_valid && !(stall_valid && stall_tid == run_tid))
      |=> (run_valid && $stable(run_tid)));

   // R4
   idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_valid && !done_valid) |=> (!run_valid && !wake && ri_valid == '0));

   logic unused_ok;
   assign unused_ok = ^{stall_stage, stall_tag, switch_fail, ri_tid, ri_tag};
endmodule

bind swmiss_sched swmiss_sched_chk #(
   .NUM_THREADS (NUM_THREADS),
   .NUM_STAGES  (NUM_STAGES),
   .TAG_W       (TAG_W),
   .TID_W       (TID_W),
   .STG_W       (STG_W)
) u_chk (.*);

// File: tb/swmiss_sched_test.sv
module swmiss_sched_test;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4, NS = 3, TW = 16, IW = 2, SW = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            stall_valid;
   logic [IW-1:0]   stall_tid;
   logic [SW-1:0]   stall_stage;
   logic [TW-1:0]   stall_tag;
   logic            done_valid;
   logic [IW-1:0]   done_tid;
   logic            run_valid;
   logic [IW-1:0]   run_tid;
   logic            wake;
   logic            switch_fail;
   logic [NS-1:0]   ri_valid;
   logic [IW-1:0]   ri_tid;
   logic [NS*TW-1:0] ri_tag;

   int n_run  = 0;
   int n_fail = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swmiss_sched #(.NUM_THREADS(NT), .NUM_STAGES(NS), .TAG_W(TW)) uut (
      .clk(clk), .rst_n(rst_n),
      .stall_valid(stall_valid), .stall_tid(stall_tid),
      .stall_stage(stall_stage), .stall_tag(stall_tag),
      .done_valid(done_valid), .done_tid(done_tid),
      .run_valid(run_valid), .run_tid(run_tid), .wake(wake),
      .switch_fail(switch_fail), .ri_valid(ri_valid),
      .ri_tid(ri_tid), .ri_tag(ri_tag)
   );

   typedef struct packed {
      logic [3:0]    rq;
      logic          sv;
      logic [IW-1:0] st;
      logic [SW-1:0] ss;
      logic [TW-1:0] tag;
      logic          dv;
      logic [IW-1:0] dt;
      logic          erv;
      logic [IW-1:0] ert;
      logic          ew;
      logic          ef;
      logic [NS-1:0] em;
      logic [IW-1:0] eit;
      logic [TW-1:0] etag;
   } vec_t;

   // fields: req, stall v/tid/stage/tag, done v/tid, expected run v/tid, wake, fail, ri mask/tid/tag
   localparam vec_t VEC [18] = '{
      '{4'd5,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R5 queue T1
      '{4'd5,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R5 queue T2
      '{4'd9,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R9 duplicate T1
      '{4'd3,  1'b1, 2'd0, 2'd0, 16'hA000, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 3'b000, 2'd0, 16'h0000}, // R3 R8 T0 stalls, T1 runs
      '{4'd5,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R5 queue T0 behind T2
      '{4'd3,  1'b1, 2'd1, 2'd2, 16'hB111, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 3'b000, 2'd0, 16'h0000}, // R3 FIFO order: T2
      '{4'd7,  1'b1, 2'd2, 2'd1, 16'hC222, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 3'b001, 2'd0, 16'hA000}, // R2 R7 T0 replays stage 0
      '{4'd7,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R7 pulse lasts one cycle
      '{4'd11, 1'b1, 2'd3, 2'd0, 16'hDEAD, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R11 stall from idle thread
      '{4'd4,  1'b1, 2'd0, 2'd1, 16'hE333, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 3'b000, 2'd0, 16'h0000}, // R4 empty queue
      '{4'd11, 1'b1, 2'd0, 2'd0, 16'hF444, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R11 stall while idle
      '{4'd6,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 3'b010, 2'd2, 16'hC222}, // R6 T2 starts, replays
      '{4'd9,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R9 done for running
      '{4'd10, 1'b1, 2'd2, 2'd2, 16'h1234, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 3'b100, 2'd1, 16'hB111}, // R10 suspend, then T1
      '{4'd5,  1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 3'b000, 2'd0, 16'h0000}, // R5 queue T0
      '{4'd10, 1'b1, 2'd1, 2'd0, 16'h5555, 1'b1, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 3'b010, 2'd0, 16'hE333}, // R10 T0 runs, T1 queued
      '{4'd3,  1'b1, 2'd0, 2'd2, 16'h6666, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 3'b001, 2'd1, 16'h5555}, // R3 R7 T1 back
      '{4'd10, 1'b1, 2'd1, 2'd1, 16'h7777, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 3'b010, 2'd1, 16'h7777}  // R10 same-cycle replay
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      stall_valid = 1'b0; stall_tid = '0; stall_stage = '0; stall_tag = '0;
      done_valid = 1'b0;  done_tid = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      @(posedge clk); #1;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check_reset_state(input string tag);
      // R1 reset values
      check(run_valid == 1'b1, {tag, " R1 run_valid"}, run_valid, 1);
      check(run_tid == '0, {tag, " R1 run_tid"}, run_tid, 0);
      check(!wake && !switch_fail, {tag, " R1 pulses"}, {wake, switch_fail}, 0);
      check(ri_valid == '0, {tag, " R1 ri_valid"}, ri_valid, 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      do_reset();
      @(posedge clk); #1;
      check_reset_state("initial");

      for (int i = 0; i < 18; i++) begin
         vec_t v;
         string rq;
         v = VEC[i];
         rq = $sformatf("R%0d vec%0d", v.rq, i);
         @(negedge clk);
         stall_valid = v.sv; stall_tid = v.st; stall_stage = v.ss; stall_tag = v.tag;
         done_valid  = v.dv; done_tid  = v.dt;
         @(posedge clk); #1;
         check(run_valid == v.erv, {rq, " run_valid"}, run_valid, v.erv);
         if (v.erv) check(run_tid == v.ert, {rq, " run_tid"}, run_tid, v.ert);
         check(wake == v.ew, {rq, " wake"}, wake, v.ew);
         check(switch_fail == v.ef, {rq, " switch_fail"}, switch_fail, v.ef);
         check(ri_valid == v.em, {rq, " ri_valid"}, ri_valid, v.em);
         if (v.em != '0) begin
            check(ri_tid == v.eit, {rq, " ri_tid"}, ri_tid, v.eit);
            for (int s = 0; s < NS; s++)
               if (v.em[s])
                  check(ri_tag[s*TW +: TW] == v.etag, {rq, " ri_tag"}, ri_tag[s*TW +: TW], v.etag);
         end
      end

      // reset in mid-run clears running state, queue and slots
      do_reset();
      @(posedge clk); #1;
      check_reset_state("mid-run");

      // R4 after reset the queue is empty: stalling T0 fails the switch
      @(negedge clk);
      stall_valid = 1'b1; stall_tid = 2'd0; stall_stage = 2'd2; stall_tag = 16'h9999;
      @(posedge clk); #1;
      check(!run_valid && switch_fail, "R4 post-reset switch", {run_valid, switch_fail}, 1);

      // R7 R1 restart T0: only the slot just written replays (older slots were cleared by reset)
      @(negedge clk);
      idle_inputs();
      done_valid = 1'b1; done_tid = 2'd0;
      @(posedge clk); #1;
      check(ri_valid == 3'b100, "R7 post-reset replay mask", ri_valid, 3'b100);
      check(ri_tag[2*TW +: TW] == 16'h9999, "R7 post-reset replay tag", ri_tag[2*TW +: TW], 16'h9999);

      @(negedge clk);
      idle_inputs();
      @(posedge clk); #1;
      check(run_valid && run_tid == 2'd0 && !wake, "R9 steady after replay", {run_valid, wake}, 2);

      finish_run();
   end
endmodule